// File: doc/BRIEF.md
# Saturating Arithmetic Unit with Sticky Overflow Flag

This block is a 32-bit arithmetic unit whose operations clamp instead of wrapping. It adds and subtracts in signed or unsigned form with the result held at the representable limit, and it limits a value to a programmable number of bits, either as one full word or as two independent 16-bit halves. A further add mode returns the ordinary wrapped sum and only records whether a signed overflow took place.

Every operation that has to clamp raises a shared sticky flag. The flag stays up across any number of later operations until the caller pulses the clear input. A caller issues one operation per cycle with `in_valid`. The result and the flag are registered and appear on the cycle after the operation is issued.

Top module: `sat_alu`

## Requirements
- R1: Opcode 0 (signed add): when both operands have the same sign and the wrapped sum has a different sign, the result is 0x7FFFFFFF if `in_a` is non-negative and 0x80000000 if it is negative, and the sticky flag is set. Otherwise the result is the sum.
- R2: Opcode 1 (signed subtract): when the operands differ in sign and the wrapped difference differs in sign from `in_a`, the result clamps by the sign of `in_a` as in R1 and the sticky flag is set. Otherwise the result is `in_a - in_b`.
- R3: Opcode 2 (unsigned add) clamps to 0xFFFFFFFF when the sum carries out. Opcode 3 (unsigned subtract) clamps to 0 when `in_b > in_a`. Both set the sticky flag when they clamp.
- R4: Opcode 4 (wrapping add) always returns the wrapped sum. It sets the sticky flag exactly when a signed add would overflow.
- R5: Opcode 5 (signed word limit to width n = `in_width`) works as follows. If `in_a` shifted arithmetically right by n is positive, the result is 2^n-1. If that shifted value is below -1, the result is the bitwise complement of 2^n-1. In both of these cases the flag is set. Otherwise `in_a` passes through.
- R6: Opcode 6 (unsigned word limit to width n): a negative `in_a` gives 0, a value above 2^n-1 gives 2^n-1, and either case sets the flag. Otherwise `in_a` passes through.
- R7: Opcodes 7 (signed) and 8 (unsigned) apply the R5 and R6 rules separately to the sign-extended halves `in_a[15:0]` and `in_a[31:16]`. Both halves use the same width, and each 16-bit result goes back into its own half. A width above 15 is treated as 15. A clamp in either half sets the flag.
- R8: Once set, the sticky flag stays set through any later operation or idle cycle until `flag_clr` is asserted. No operation clears it.
- R9: `flag_clr` clears the flag on the next cycle even when a clamping operation is issued in the same cycle. Synchronous reset clears the flag, the result and `out_valid`.
- R10: `out_result` and `out_valid` update one cycle after `in_valid` is asserted. With `in_valid` low, `out_valid` falls and `out_result` holds its last value.
- R11: Opcodes 9 to 15 produce a result of 0 and never set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_op | input | 4 | Operation code (see requirements) |
| in_a | input | 32 | First operand / value to limit |
| in_b | input | 32 | Second operand for add and subtract |
| in_width | input | 5 | Limit width n for opcodes 5 to 8 |
| flag_clr | input | 1 | Clear the sticky flag |
| out_valid | output | 1 | Result register loaded last cycle |
| out_result | output | 32 | Registered result |
| out_sticky | output | 1 | Sticky clamp flag |

## Verification
The hardest cases to reach from the ports are the ones where the flag sees two causes at once. These are a clear that coincides with a clamping operation, and a halfword operation where only one half clamps. The stimulus reaches them by issuing a saturating add together with `flag_clr`, and by choosing halfword operands in which only the upper half leaves range. The halfword width rule is exercised with `in_width` of 20 and a lower half of 0x7FFF. That value would clamp if only the low four width bits were used, and it passes through only if the width is limited to 15. Before each table entry the flag is cleared on an idle cycle, so the flag reading afterwards reflects that entry alone.

// File: rtl/sat_pkg.sv
package sat_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_SADD  = 4'd0,
        OP_SSUB  = 4'd1,
        OP_UADD  = 4'd2,
        OP_USUB  = 4'd3,
        OP_WADD  = 4'd4,
        OP_SLIMW = 4'd5,
        OP_ULIMW = 4'd6,
        OP_SLIMH = 4'd7,
        OP_ULIMH = 4'd8
    } sat_op_e;

    // Signed overflow from the sign bits of the operands and the wrapped result
    function automatic logic sign_ovf(input logic sa, input logic sb,
                                      input logic sr, input logic is_sub);
        logic same;
        same = ~(sa ^ sb);
        return (is_sub ? ~same : same) & (sr ^ sa);
    endfunction

endpackage

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_pkg::*;
#(
    parameter int DW = 32
) (
    input  sat_op_e         op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    output logic [DW-1:0]   res,
    output logic            sat
);
    localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0]   sum_x, dif_x;
    logic [DW-1:0] sum, dif, lim;
    logic          ovf_add, ovf_sub;

    always_comb begin
        sum_x   = {1'b0, a} + {1'b0, b};
        dif_x   = {1'b0, a} - {1'b0, b};
        sum     = sum_x[DW-1:0];
        dif     = dif_x[DW-1:0];
        ovf_add = sign_ovf(a[DW-1], b[DW-1], sum[DW-1], 1'b0);
        ovf_sub = sign_ovf(a[DW-1], b[DW-1], dif[DW-1], 1'b1);
        lim     = a[DW-1] ? NEG_MIN : POS_MAX;
        res     = '0;
        sat     = 1'b0;
        unique case (op)
            OP_SADD: begin res = ovf_add ? lim : sum; sat = ovf_add; end
            OP_SSUB: begin res = ovf_sub ? lim : dif; sat = ovf_sub; end
            OP_UADD: begin res = sum_x[DW] ? '1 : sum; sat = sum_x[DW]; end
            OP_USUB: begin res = dif_x[DW] ? '0 : dif; sat = dif_x[DW]; end
            OP_WADD: begin res = sum; sat = ovf_add; end
            default: begin res = '0; sat = 1'b0; end
        endcase
    end
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp #(
    parameter int W  = 32,
    localparam int NW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [NW-1:0] n,
    input  logic          is_signed,
    output logic [W-1:0]  res,
    output logic          sat
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0]        mask;
    logic signed [W-1:0] top;

    always_comb begin
        mask = (ONE << n) - ONE;
        top  = $signed(val) >>> n;
        res  = val;
        sat  = 1'b0;
        if (is_signed) begin
            if (top > 0) begin
                res = mask;  sat = 1'b1;
            end else if (top < -1) begin
                res = ~mask; sat = 1'b1;
            end
        end else begin
            if (val[W-1]) begin
                res = '0;   sat = 1'b1;
            end else if (val > mask) begin
                res = mask; sat = 1'b1;
            end
        end
    end
endmodule

// File: rtl/sat_alu.sv
module sat_alu
    import sat_pkg::*;
#(
    parameter int DW = 32,
    localparam int WW    = $clog2(DW),
    localparam int LANES = 2,
    localparam int HW    = DW / LANES,
    localparam int HNW   = $clog2(HW)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OPW-1:0]  in_op,
    input  logic [DW-1:0]   in_a,
    input  logic [DW-1:0]   in_b,
    input  logic [WW-1:0]   in_width,
    input  logic            flag_clr,
    output logic            out_valid,
    output logic [DW-1:0]   out_result,
    output logic            out_sticky
);
    sat_op_e        op;
    logic [DW-1:0]  as_res, wl_res, nxt_res;
    logic           as_sat, wl_sat, nxt_sat;
    logic [HW-1:0]  hl_res [LANES];
    logic [LANES-1:0] hl_sat;
    logic [HNW-1:0] h_width;

    assign op = sat_op_e'(in_op);
    assign h_width = (in_width >= WW'(HW)) ? HNW'(HW - 1) : in_width[HNW-1:0];

    sat_addsub #(.DW(DW)) u_addsub (
        .op(op), .a(in_a), .b(in_b), .res(as_res), .sat(as_sat)
    );

    sat_clamp #(.W(DW)) u_word (
        .val(in_a), .n(in_width), .is_signed(op == OP_SLIMW),
        .res(wl_res), .sat(wl_sat)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sat_clamp #(.W(HW)) u_half (
            .val(in_a[g*HW +: HW]), .n(h_width), .is_signed(op == OP_SLIMH),
            .res(hl_res[g]), .sat(hl_sat[g])
        );
    end

    always_comb begin
        unique case (op)
            OP_SADD, OP_SSUB, OP_UADD, OP_USUB, OP_WADD: begin
                nxt_res = as_res; nxt_sat = as_sat;
            end
            OP_SLIMW, OP_ULIMW: begin
                nxt_res = wl_res; nxt_sat = wl_sat;
            end
            OP_SLIMH, OP_ULIMH: begin
                nxt_res = {hl_res[1], hl_res[0]}; nxt_sat = |hl_sat;
            end
            default: begin
                nxt_res = '0; nxt_sat = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_sticky <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_result <= nxt_res;
            if (flag_clr) out_sticky <= 1'b0;
            else if (in_valid && nxt_sat) out_sticky <= 1'b1;
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R10
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> (!out_valid && $stable(out_result))); // R10
    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst) flag_clr |=> !out_sticky); // R9
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst) (out_sticky && !flag_clr) |=> out_sticky); // R8
    AST_HALF_SETS: assert property (@(posedge clk) disable iff (rst) (in_valid && !flag_clr && (op == OP_SLIMH || op == OP_ULIMH) && (hl_sat != '0)) |=> out_sticky); // R7
    AST_ADD_SETS: assert property (@(posedge clk) disable iff (rst) (in_valid && !flag_clr && op inside {OP_SADD, OP_SSUB, OP_UADD, OP_USUB, OP_WADD} && as_sat) |=> out_sticky); // R1
endmodule

// File: tb/sim_sat_alu.sv
module sim_sat_alu;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  in_op = '0;
    logic [31:0] in_a = '0, in_b = '0;
    logic [4:0]  in_width = '0;
    logic        flag_clr = 1'b0;
    logic        out_valid, out_sticky;
    logic [31:0] out_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sat_alu u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
        .in_a(in_a), .in_b(in_b), .in_width(in_width), .flag_clr(flag_clr),
        .out_valid(out_valid), .out_result(out_result), .out_sticky(out_sticky)
    );

    localparam int N = 26;
    localparam logic [3:0]  T_OP [N] = '{4'd0, 4'd0, 4'd0, 4'd1, 4'd1, 4'd1, 4'd2, 4'd2, 4'd3, 4'd3,
                                         4'd4, 4'd4, 4'd5, 4'd5, 4'd5, 4'd5, 4'd6, 4'd6, 4'd6, 4'd7,
                                         4'd7, 4'd7, 4'd8, 4'd8, 4'd8, 4'd9};
    localparam logic [31:0] T_A [N] = '{32'h7FFFFFFF, 32'h80000000, 32'h00000005, 32'h80000000, 32'h7FFFFFFF,
                                        32'h0000000A, 32'hFFFFFFF0, 32'h00000001, 32'h00000005, 32'h00000009,
                                        32'h7FFFFFFF, 32'hFFFFFFFF, 32'h000003E8, 32'hFFFFFC18, 32'hFFFFFF00,
                                        32'h80000000, 32'h0000012C, 32'hFFFFFFFF, 32'h000000FF, 32'h0100FF00,
                                        32'h0003FFFE, 32'h00007FFF, 32'h80000010, 32'h00050003, 32'h00200001,
                                        32'h7FFFFFFF};
    localparam logic [31:0] T_B [N] = '{32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFD, 32'h00000001, 32'hFFFFFFFF,
                                        32'h00000003, 32'h00000020, 32'h00000002, 32'h00000006, 32'h00000004,
                                        32'h00000001, 32'h00000001, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
                                        32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h00000001};
    localparam logic [4:0]  T_W [N] = '{5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd0,
                                        5'd0, 5'd0, 5'd8, 5'd8, 5'd8, 5'd31, 5'd8, 5'd8, 5'd8, 5'd4,
                                        5'd4, 5'd20, 5'd4, 5'd4, 5'd4, 5'd0};
    localparam logic [31:0] T_RES [N] = '{32'h7FFFFFFF, 32'h80000000, 32'h00000002, 32'h80000000, 32'h7FFFFFFF,
                                          32'h00000007, 32'hFFFFFFFF, 32'h00000003, 32'h00000000, 32'h00000005,
                                          32'h80000000, 32'h00000000, 32'h000000FF, 32'hFFFFFF00, 32'hFFFFFF00,
                                          32'h80000000, 32'h000000FF, 32'h00000000, 32'h000000FF, 32'h000FFFF0,
                                          32'h0003FFFE, 32'h00007FFF, 32'h0000000F, 32'h00050003, 32'h000F0001,
                                          32'h00000000};
    localparam logic        T_SAT [N] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0,
                                          1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1,
                                          1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2, 4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7, 4'd8: return "R7";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] w, input logic v, input logic clr);
        in_op = op; in_a = a; in_b = b; in_width = w; in_valid = v; flag_clr = clr;
        @(negedge clk);
        in_valid = 1'b0; flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9", {31'd0, out_valid}, 32'd0);
        chk("R9", out_result, 32'd0);
        chk("R9", {31'd0, out_sticky}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int i = 0; i < N; i++) begin
            drive(4'd0, 32'd0, 32'd0, 5'd0, 1'b0, 1'b1);
            drive(T_OP[i], T_A[i], T_B[i], T_W[i], 1'b1, 1'b0);
            chk(tag_of(T_OP[i]), out_result, T_RES[i]);
            chk(tag_of(T_OP[i]), {31'd0, out_sticky}, {31'd0, T_SAT[i]});
            chk("R10", {31'd0, out_valid}, 32'd1);
        end

        // R8: flag survives non-clamping operations and idle cycles
        drive(4'd0, 32'd0, 32'd0, 5'd0, 1'b0, 1'b1);
        drive(4'd3, 32'd1, 32'd2, 5'd0, 1'b1, 1'b0);
        drive(4'd0, 32'd1, 32'd2, 5'd0, 1'b1, 1'b0);
        chk("R8", out_result, 32'd3);
        chk("R8", {31'd0, out_sticky}, 32'd1);
        drive(4'd5, 32'd3, 32'd0, 5'd4, 1'b1, 1'b0);
        drive(4'd0, 32'd0, 32'd0, 5'd0, 1'b0, 1'b0);
        chk("R8", {31'd0, out_sticky}, 32'd1);

        // R9: clear beats a same-cycle clamp, result still loads
        drive(4'd0, 32'h7FFFFFFF, 32'd1, 5'd0, 1'b1, 1'b1);
        chk("R9", out_result, 32'h7FFFFFFF);
        chk("R9", {31'd0, out_sticky}, 32'd0);

        // R10: idle cycle holds result, drops valid
        drive(4'd0, 32'd9, 32'd9, 5'd0, 1'b0, 1'b0);
        chk("R10", out_result, 32'h7FFFFFFF);
        chk("R10", {31'd0, out_valid}, 32'd0);

        // R9: reset clears a set flag
        drive(4'd2, 32'hFFFFFFFF, 32'd1, 5'd0, 1'b1, 1'b0);
        chk("R3", {31'd0, out_sticky}, 32'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R9", {31'd0, out_sticky}, 32'd0);
        chk("R9", out_result, 32'd0);

        finish_run();
    end
endmodule